// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block chooses where each of the two source operands of the instruction in decode comes from in a five-stage in-order pipeline. It takes the two source register numbers of that instruction and compares them with the destination register numbers of the two older instructions still in flight: the one in execute and the one in the memory stage. From that comparison it forms one 2-bit select code per operand.

Each select code steers a multiplexer. The choices are the register-file read value, the result of the instruction in execute, or the memory-stage value. The memory-stage value is either load data or the older ALU result, picked by a flag that instruction carries. The chosen value is captured in the operand register that feeds the execute stage on the next clock edge.

The select codes are combinational, so they are valid in the same cycle as the inputs. The operand registers are clocked and have a synchronous active-high reset.

Top module: `fwd_unit`

## Requirements
- R1: When a source register matches neither older instruction's qualified destination, its select code is 00 (register file), and the code 11 never appears on either select output.
- R2: A source equal to the execute-stage destination, with that destination nonzero and its write enable set, gets select code 01. Its operand register then loads the execute-stage result.
- R3: A source that fails the execute-stage condition but equals the nonzero memory-stage destination, with the memory-stage write enable set, gets select code 10.
- R4: When a source matches both the execute-stage and the memory-stage destination, select code 01 wins, so the younger result is used.
- R5: A destination register number of 0 never causes forwarding from either stage, even when the source is 0 and the write enable is set.
- R6: A cleared write enable on a stage disables matching against that stage. A cleared execute-stage enable therefore lets a memory-stage match produce 10.
- R7: Under select code 10, the operand register loads the memory-stage load data when the load flag is 1, and the memory-stage ALU result when the flag is 0.
- R8: Operand B follows the same rules using the second source register, independently of operand A, and the two select outputs may differ in the same cycle.
- R9: Each operand register loads, on each rising clock edge, the value chosen by that cycle's select code. Under code 00 that value is its register-file input. A synchronous reset clears both registers to 0.
- R10: With a load writing register 4 in the memory stage, an add writing register 7 in execute, and an instruction reading 4 and 7 in decode, operand A gets code 10 and receives the load data, and operand B gets code 01 and receives the add result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the operand registers |
| dec_src_a | input | 5 | First source register number of the decode instruction |
| dec_src_b | input | 5 | Second source register number of the decode instruction |
| rf_val_a | input | 32 | Register-file read value for operand A |
| rf_val_b | input | 32 | Register-file read value for operand B |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_result | input | 32 | Result of the execute-stage instruction |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage value is load data (1) or ALU result (0) |
| mem_load_data | input | 32 | Load data of the memory-stage instruction |
| mem_alu_res | input | 32 | Registered ALU result of the memory-stage instruction |
| sel_a | output | 2 | Operand A select: 00 register file, 01 execute, 10 memory |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | 32 | Registered operand A for the execute stage |
| opnd_b | output | 32 | Registered operand B for the execute stage |

## Verification
The directed cases each target one outcome:
- A match against only one stage isolates the 01 path from the 10 path.
- A match against both stages exposes a reversed priority.
- Zero destinations and cleared write enables separate a real match from a mere equality of register numbers.
- Flipping the load flag under a memory-stage match tells load data from the older ALU result.

Every input source value is distinct, so a wrong multiplexer leg is visible in the operand registers. An exhaustive sweep over small register numbers and all enable combinations compares both select outputs and both operand registers against a reference model. The sweep gives the two sources different numbers, so a mixed-up operand shows as a mismatch. The three-instruction load, add and dependent sequence is checked as a case of its own.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr_en,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  output fwd_sel_e         sel
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic hit_ex;
  logic hit_mem;

  assign hit_ex  = ex_wr_en  && (ex_dst  != ZERO_REG) && (src == ex_dst);
  assign hit_mem = mem_wr_en && (mem_dst != ZERO_REG) && (src == mem_dst);

  // younger instruction takes priority
  always_comb begin
    if (hit_ex)       sel = FWD_EX;
    else if (hit_mem) sel = FWD_MEM;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] opnd
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    case (sel)
      FWD_EX:  pick = ex_val;
      FWD_MEM: pick = mem_val;
      default: pick = rf_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) opnd <= '0;
    else     opnd <= pick;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [DATA_W-1:0] rf_val_a,
  input  logic [DATA_W-1:0] rf_val_b,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              ex_wr_en,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] mem_load_data,
  input  logic [DATA_W-1:0] mem_alu_res,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int NUM_OPND = 2;

  logic [NUM_OPND-1:0][REG_W-1:0]  src_v;
  logic [NUM_OPND-1:0][DATA_W-1:0] rf_v;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnd_v;
  fwd_sel_e                        sel_v [NUM_OPND];
  logic [DATA_W-1:0]               mem_fwd;

  assign src_v[0] = dec_src_a;
  assign src_v[1] = dec_src_b;
  assign rf_v[0]  = rf_val_a;
  assign rf_v[1]  = rf_val_b;

  // shared memory-stage forward value
  assign mem_fwd = mem_is_load ? mem_load_data : mem_alu_res;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    fwd_match #(.REG_W(REG_W)) u_match (
      .src       (src_v[i]),
      .ex_dst    (ex_dst),
      .ex_wr_en  (ex_wr_en),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .sel       (sel_v[i])
    );

    fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel_v[i]),
      .rf_val  (rf_v[i]),
      .ex_val  (ex_result),
      .mem_val (mem_fwd),
      .opnd    (opnd_v[i])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  dec_src_a,
  input logic [REG_W-1:0]  dec_src_b,
  input logic [DATA_W-1:0] rf_val_a,
  input logic [REG_W-1:0]  ex_dst,
  input logic              ex_wr_en,
  input logic [DATA_W-1:0] ex_result,
  input logic [REG_W-1:0]  mem_dst,
  input logic              mem_wr_en,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a
);
  p_no_code3_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  p_ex_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (ex_wr_en && ex_dst != '0 && dec_src_a == ex_dst) |-> sel_a == 2'b01);

  p_ex_value_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b01) |=> opnd_a == $past(ex_result));

  p_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_wr_en && mem_wr_en && ex_dst != '0 && ex_dst == mem_dst &&
     dec_src_b == ex_dst) |-> sel_b == 2'b01);

  p_zero_dst_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == '0 && mem_dst == '0) |-> (sel_a == 2'b00 && sel_b == 2'b00));

  p_wr_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!ex_wr_en && !mem_wr_en) |-> (sel_a == 2'b00 && sel_b == 2'b00));

  p_rf_value_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b00) |=> opnd_a == $past(rf_val_a));
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_src_a (dec_src_a),
  .dec_src_b (dec_src_b),
  .rf_val_a  (rf_val_a),
  .ex_dst    (ex_dst),
  .ex_wr_en  (ex_wr_en),
  .ex_result (ex_result),
  .mem_dst   (mem_dst),
  .mem_wr_en (mem_wr_en),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .opnd_a    (opnd_a)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam logic [31:0] V_RFA  = 32'hA0A0_0001;
  localparam logic [31:0] V_RFB  = 32'hB0B0_0002;
  localparam logic [31:0] V_EX   = 32'hEEEE_0003;
  localparam logic [31:0] V_LD   = 32'h1111_0004;
  localparam logic [31:0] V_ALU2 = 32'h2222_0005;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dec_src_a = '0, dec_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic [31:0] rf_val_a = V_RFA, rf_val_b = V_RFB, ex_result = V_EX;
  logic [31:0] mem_load_data = V_LD, mem_alu_res = V_ALU2;
  logic        ex_wr_en = 1'b0, mem_wr_en = 1'b0, mem_is_load = 1'b0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  fwd_unit dut (
    .clk(clk), .rst(rst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .ex_dst(ex_dst), .ex_wr_en(ex_wr_en), .ex_result(ex_result),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
    .mem_load_data(mem_load_data), .mem_alu_res(mem_alu_res),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic [4:0] ed,
                                         input logic ew, input logic [4:0] md,
                                         input logic mw);
    if (ew && ed != 0 && s == ed)      return 2'b01;
    else if (mw && md != 0 && s == md) return 2'b10;
    else                               return 2'b00;
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'b01:   return ex_result;
      2'b10:   return mem_is_load ? mem_load_data : mem_alu_res;
      default: return rf;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_in(input logic [4:0] sa, input logic [4:0] sb,
                        input logic [4:0] ed, input logic ew,
                        input logic [4:0] md, input logic mw, input logic ml);
    dec_src_a = sa; dec_src_b = sb; ex_dst = ed; ex_wr_en = ew;
    mem_dst = md; mem_wr_en = mw; mem_is_load = ml;
  endtask

  // checks select outputs now and operand registers after the next edge
  task automatic run_case(input string req);
    logic [1:0]  ea, eb;
    logic [31:0] va, vb;
    #2;
    ea = ref_sel(dec_src_a, ex_dst, ex_wr_en, mem_dst, mem_wr_en);
    eb = ref_sel(dec_src_b, ex_dst, ex_wr_en, mem_dst, mem_wr_en);
    va = ref_val(ea, rf_val_a);
    vb = ref_val(eb, rf_val_b);
    chk({req, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    chk({req, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    @(posedge clk); #1;
    chk({req, " opnd_a"}, opnd_a, va);
    chk({req, " opnd_b"}, opnd_b, vb);
  endtask

  task automatic t_reset;
    set_in(5'd3, 5'd3, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 reset opnd_a", opnd_a, 32'd0);
    chk("R9 reset opnd_b", opnd_b, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_no_match;
    set_in(5'd1, 5'd2, 5'd5, 1'b1, 5'd6, 1'b1, 1'b0);
    run_case("R1 no match");
    chk("R1 sel_a rf", {30'd0, sel_a}, 32'd0);
    chk("R9 rf value", opnd_a, V_RFA);
  endtask

  task automatic t_ex_only;
    set_in(5'd9, 5'd2, 5'd9, 1'b1, 5'd4, 1'b1, 1'b1);
    run_case("R2 ex only");
    chk("R2 opnd_a ex", opnd_a, V_EX);
  endtask

  task automatic t_mem_only;
    set_in(5'd3, 5'd3, 5'd8, 1'b1, 5'd3, 1'b1, 1'b0);
    run_case("R3 mem only");
    chk("R3 sel_b mem", {30'd0, sel_b}, 32'd2);
  endtask

  task automatic t_priority;
    set_in(5'd12, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1, 1'b1);
    run_case("R4 both match");
    chk("R4 opnd_b younger", opnd_b, V_EX);
  endtask

  task automatic t_zero_dst;
    set_in(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1);
    run_case("R5 zero dst");
    chk("R5 opnd_a rf", opnd_a, V_RFA);
    chk("R5 opnd_b rf", opnd_b, V_RFB);
  endtask

  task automatic t_wr_disable;
    set_in(5'd7, 5'd7, 5'd7, 1'b0, 5'd7, 1'b1, 1'b0);
    run_case("R6 ex disabled");
    chk("R6 sel_a falls to mem", {30'd0, sel_a}, 32'd2);
    set_in(5'd7, 5'd7, 5'd7, 1'b0, 5'd7, 1'b0, 1'b0);
    run_case("R6 both disabled");
    chk("R6 opnd_a rf", opnd_a, V_RFA);
  endtask

  task automatic t_mem_source;
    set_in(5'd5, 5'd5, 5'd1, 1'b1, 5'd5, 1'b1, 1'b1);
    run_case("R7 load data");
    chk("R7 opnd_a load", opnd_a, V_LD);
    mem_is_load = 1'b0;
    run_case("R7 alu result");
    chk("R7 opnd_a alu", opnd_a, V_ALU2);
  endtask

  task automatic t_independent;
    set_in(5'd10, 5'd11, 5'd11, 1'b1, 5'd10, 1'b1, 1'b0);
    run_case("R8 independent");
    chk("R8 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R8 sel_b", {30'd0, sel_b}, 32'd1);
  endtask

  task automatic t_sequence;
    set_in(5'd4, 5'd7, 5'd7, 1'b1, 5'd4, 1'b1, 1'b1);
    #2;
    chk("R10 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R10 sel_b", {30'd0, sel_b}, 32'd1);
    @(posedge clk); #1;
    chk("R10 opnd_a", opnd_a, V_LD);
    chk("R10 opnd_b", opnd_b, V_EX);
  endtask

  task automatic t_sweep;
    for (int sa = 0; sa < 4; sa++)
      for (int ed = 0; ed < 4; ed++)
        for (int md = 0; md < 4; md++)
          for (int en = 0; en < 8; en++) begin
            set_in(5'(sa), 5'(3 - sa), 5'(ed), en[0], 5'(md), en[1], en[2]);
            rf_val_a = V_RFA ^ 32'(sa);
            rf_val_b = V_RFB ^ 32'(en);
            run_case("R8 sweep");
          end
    rf_val_a = V_RFA;
    rf_val_b = V_RFB;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_no_match();
    t_ex_only();
    t_mem_only();
    t_priority();
    t_zero_dst();
    t_wr_disable();
    t_mem_source();
    t_independent();
    t_sequence();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule